// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Detector

This block watches a serial bit stream, taking one bit on each clock where the qualifier is high. It recognises two five-bit patterns with a single shared state machine, and it reports a two-bit result code. The first pattern is 1,1,0,0,1 (oldest bit first) and reports code 01. The second pattern is 1,0,0,1,0 and reports code 10. Any other outcome reports 00. The machine keeps only the longest recent suffix that could still grow into either pattern. Common prefixes therefore share states, and every overlap is found, both inside one pattern and from one pattern into the other.

The same result is given in two timings. The Mealy output is combinational from the stored history and the incoming bit, so it reports a match in the cycle that delivers the completing bit. The Moore output comes from a second machine that has dedicated terminal states, so it reports the same code one clock later. It keeps that code until the next accepted bit.

Top module: `dual_pattern_detector`

## Requirements
- R1: When the last five accepted bits, oldest first, are 1,1,0,0,1, `mealy_code` is 2'b01 in the cycle in which the fifth bit is presented with `bit_vld` high.
- R2: When the last five accepted bits, oldest first, are 1,0,0,1,0, `mealy_code` is 2'b10 in the cycle in which the fifth bit is presented with `bit_vld` high.
- R3: On an accepted bit that completes neither pattern, `mealy_code` is 2'b00. This includes near misses such as 1,0,0,0,1 and 1,1,0,1,0.
- R4: Matches of the same pattern may overlap. For example, 1,0,0,1,0,0,1,0 reports 10 at bit 5 and again at bit 8.
- R5: Matches of different patterns may overlap. For example, 1,1,0,0,1,0 reports 01 at bit 5 and then 10 at bit 6.
- R6: Code 2'b11 never appears on `mealy_code` or `moore_code`.
- R7: On a cycle with `bit_vld` low, `bit_in` is ignored, the history is held and `mealy_code` is 2'b00.
- R8: `moore_code` equals the `mealy_code` of the most recently accepted bit. It changes on the clock edge that accepts that bit and holds through cycles with `bit_vld` low.
- R9: A synchronous active-high `rst` clears all history and sets `moore_code` to 2'b00. No match is reported until five more bits have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| mealy_code | output | 2 | Same-cycle result code (00 none, 01 first pattern, 10 second pattern) |
| moore_code | output | 2 | Registered result code of the last accepted bit |

## Verification
Every ten-bit stream is fed after a reset. The last five bits of each stream meet every possible history, so each transition out of every shared prefix state is tried, and near misses are told apart from true matches. Directed streams separate self-overlap from cross-pattern overlap, and they show that a reset in the middle of a pattern discards the partial history. A long random stream with random gaps in the qualifier shows that bits offered while the qualifier is low are ignored, and that the Moore code holds while no bit is accepted.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int CODE_W = 2;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_NONE = 2'b00;
  localparam code_t CODE_A    = 2'b01;
  localparam code_t CODE_B    = 2'b10;

  // Longest suffix of the accepted stream that is a prefix of either target.
  typedef enum logic [2:0] {
    H_NONE, H_1, H_11, H_10, H_110, H_100, H_1100, H_1001
  } hist_e;

  function automatic hist_e hist_next(hist_e s, logic b);
    hist_e n;
    case (s)
      H_NONE: n = b ? H_1    : H_NONE;
      H_1:    n = b ? H_11   : H_10;
      H_11:   n = b ? H_11   : H_110;
      H_10:   n = b ? H_1    : H_100;
      H_110:  n = b ? H_1    : H_1100;
      H_100:  n = b ? H_1001 : H_NONE;
      H_1100: n = b ? H_1001 : H_NONE;
      H_1001: n = b ? H_11   : H_10;
      default: n = H_NONE;
    endcase
    return n;
  endfunction

  function automatic code_t hit_code(hist_e s, logic b);
    if (s == H_1100 && b)       return CODE_A;
    else if (s == H_1001 && !b) return CODE_B;
    else                        return CODE_NONE;
  endfunction
endpackage

// File: rtl/seqdet_mealy_core.sv
module seqdet_mealy_core
  import seqdet_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_in,
  input  logic  bit_vld,
  output code_t code
);
  hist_e state_q;
  logic  hit_a;
  logic  hit_b;
  code_t raw_code;

  assign raw_code = hit_code(state_q, bit_in);
  assign hit_a    = bit_vld && (raw_code == CODE_A);
  assign hit_b    = bit_vld && (raw_code == CODE_B);
  assign code     = {hit_b, hit_a};

  always_ff @(posedge clk) begin
    if (rst)          state_q <= H_NONE;
    else if (bit_vld) state_q <= hist_next(state_q, bit_in);
  end

  // R6: the two detections exclude each other
  p_single_hit_r6: assert property (@(posedge clk) disable iff (rst)
    !(hit_a && hit_b));
  // R7: without a qualified bit the code is quiet and the history holds
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> code == CODE_NONE);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(state_q));
endmodule

// File: rtl/seqdet_moore_core.sv
module seqdet_moore_core
  import seqdet_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_in,
  input  logic  bit_vld,
  output code_t code
);
  // The state pair {term_q, base_q} forms the Moore machine. A terminal
  // state is a base history with a non-zero term_q.
  hist_e base_q;
  code_t term_q;
  code_t step_code;
  hist_e step_base;

  assign step_code = hit_code(base_q, bit_in);
  assign step_base = hist_next(base_q, bit_in);
  assign code      = term_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= H_NONE;
      term_q <= CODE_NONE;
    end else if (bit_vld) begin
      base_q <= step_base;
      term_q <= step_code;
    end
  end

  // R8: the output only moves on an accepted bit
  p_gap_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(code));
endmodule

// File: rtl/dual_pattern_detector.sv
module dual_pattern_detector
  import seqdet_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  output logic [CODE_W-1:0] mealy_code,
  output logic [CODE_W-1:0] moore_code
);
  code_t mealy_w;
  code_t moore_w;

  seqdet_mealy_core u_mealy (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .code(mealy_w)
  );

  seqdet_moore_core u_moore (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .code(moore_w)
  );

  assign mealy_code = mealy_w;
  assign moore_code = moore_w;

  // R6: no combined code on either output
  p_no_code11_r6: assert property (@(posedge clk) disable iff (rst)
    mealy_code != 2'b11 && moore_code != 2'b11);
  // R8: the Moore code follows the Mealy code of the accepted bit by one clock
  p_moore_lags_r8: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> moore_code == $past(mealy_code));
  // R9: reset clears the registered code
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> moore_code == CODE_NONE);
endmodule

// File: tb/tb_dual_pattern_detector.sv
`timescale 1ns/1ps
module tb_dual_pattern_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic [1:0] mealy_code;
  logic [1:0] moore_code;

  int checks = 0;
  int errors = 0;
  logic [4:0] hist = '0;
  int accepted = 0;
  int last_code = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_pattern_detector dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .mealy_code(mealy_code), .moore_code(moore_code)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b0;
    @(negedge clk);
    #1;
    chk(int'(mealy_code), 0, "R9 mealy after reset");
    chk(int'(moore_code), 0, "R9 moore after reset");
    rst = 1'b0;
    hist = '0; accepted = 0; last_code = 0;
  endtask

  task automatic step(input logic b, input logic v, input string tag);
    logic [4:0] hn;
    int exp;
    string t;
    @(negedge clk);
    bit_in = b; bit_vld = v;
    #1;
    hn = {hist[3:0], b};
    exp = 0;
    if (v && accepted >= 4) begin
      if (hn == 5'b11001)      exp = 1;
      else if (hn == 5'b10010) exp = 2;
    end
    if (tag != "")   t = tag;
    else if (!v)     t = "R7";
    else if (exp==1) t = "R1";
    else if (exp==2) t = "R2";
    else             t = "R3";
    chk(int'(mealy_code), exp, t);
    chk(int'(moore_code), last_code, "R8");
    if (mealy_code == 2'b11 || moore_code == 2'b11) chk(3, 0, "R6 code 11");
    if (v) begin
      hist = hn; accepted++; last_code = exp;
    end
  endtask

  task automatic feed(input logic [15:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) step(bits[i], 1'b1, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4: self overlap of the second pattern, then of the first
    feed(16'b10010010, 8, "R4");
    do_reset();
    feed(16'b110011001, 9, "R4");
    do_reset();
    // R5: cross-pattern overlap
    feed(16'b110010, 6, "R5");
    do_reset();
    // R3: near misses
    feed(16'b10001, 5, "R3");
    feed(16'b11010, 5, "R3");
    // R7: ignored bits in a gap must not break a pending match
    do_reset();
    feed(16'b1100, 4, "");
    step(1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, "R8 hold");
    // R9: reset mid-pattern discards history
    feed(16'b1100, 4, "");
    do_reset();
    step(1'b1, 1'b1, "R9 no match after reset");
    // all ten-bit streams
    for (int p = 0; p < 1024; p++) begin
      do_reset();
      for (int i = 9; i >= 0; i--) step(p[i], 1'b1, "");
    end
    // random stream with gaps
    do_reset();
    for (int k = 0; k < 4000; k++) step(1'($urandom), 1'(($urandom % 4) != 0), "");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule